// File: doc/BRIEF.md
# Synthesizer Serial Control Register Interface

This block is the programming front end of a frequency synthesizer. A host drives a serial data line, a serial clock and two write strobes. These load three control stores. The first is the main counter word, which holds the reference, main and swallow divide fields and a prescaler enable. The second is the fractional-modulus word. The third is an enhancement byte that carries the output-select, power-down, counter-load and lock-detect-disable flags. The block decodes the stored words into separate counter fields for the dividers downstream. When a mode input selects parallel programming, the counter fields come from pins instead.

Every input is brought into one system clock through a synchronizer. Edges on the serial clock and on the strobes are then detected inside that clock domain. The serial pins therefore clock no flop directly. The main frame and the enhancement byte use different strobes. The enhancement byte reaches its outputs through a shadow register that changes only at the end of a load. Its flags are also gated by an active-low enable pin.

Top module: `synth_serial_ctrl`

## Requirements
- R1: After reset every counter field output and every flag output reads 0.
- R2: On each detected rising edge of `sclk` while `ewr` is low, `sdata` shifts into a 21-bit frame register. The first bit in becomes the most significant bit. The last (21st) bit is the address bit.
- R3: A frame with address bit 0 loads the primary word. Counting the 20 data bits first-in to last-in as positions 0 to 19: positions 0-1 are the upper two bits of `out_r` (bits 5:4), 2-3 are `out_m` bits 8:7, 4 is `out_pre`, 5-11 are `out_m` bits 6:0, 12-15 are `out_r` bits 3:0 and 16-19 are `out_a` bits 3:0, each group most significant first.
- R4: A frame with address bit 1 loads `out_k` from data positions 0-17, most significant first. Position 18 and 19 are ignored. The primary word is unchanged.
- R5: A frame takes effect only on a rising edge of `swr` while `ewr` is low. Shifting bits without that edge leaves the outputs unchanged.
- R6: When more than 21 bits are shifted before the commit, only the last 21 bits define the frame.
- R7: On a rising edge of `sclk` while `ewr` is high and `swr` is low, `sdata` shifts into the enhancement shift register, first bit most significant. Clock edges while `ewr` and `swr` are both high shift nothing.
- R8: The enhancement shadow takes the shift register only on a falling edge of `ewr`. For an 8-bit byte sent first-in to last-in as b7..b0, b7 and b6 are spare, b5 is `phase_sel`, b4 `pwr_down`, b3 `cnt_load`, b2 `msel_sel`, b1 `cmp_sel` and b0 `lock_det_off`. During a load the flags keep their previous values.
- R9: The flag outputs equal the shadow bits while `enh_n` is low, and all read 0 while `enh_n` is high.
- R10: While `direct` is high, the counter field outputs follow `par_r`, `par_m`, `par_pre`, `par_a` and `par_k`, and serial commits are ignored. When `direct` returns low, the outputs show the serially stored words that were held before direct mode.
- R11: Serial clock edges during an enhancement load leave the 21-bit frame register unchanged. A later `swr` commit with `ewr` low therefore loads the bits shifted before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata | input | 1 | Serial data |
| sclk | input | 1 | Serial clock, sampled on its rising edge |
| swr | input | 1 | Frame commit strobe, rising edge |
| ewr | input | 1 | Enhancement load strobe, high during load, capture on falling edge |
| enh_n | input | 1 | Active-low enhancement flag enable |
| direct | input | 1 | High selects the parallel counter pins |
| par_r | input | 6 | Parallel reference divide field |
| par_m | input | 9 | Parallel main divide field |
| par_pre | input | 1 | Parallel prescaler enable |
| par_a | input | 4 | Parallel swallow field |
| par_k | input | 18 | Parallel fractional-modulus word |
| out_r | output | 6 | Reference divide field |
| out_m | output | 9 | Main divide field |
| out_pre | output | 1 | Prescaler enable |
| out_a | output | 4 | Swallow field |
| out_k | output | 18 | Fractional-modulus word |
| phase_sel | output | 1 | Phase-detector output select flag |
| pwr_down | output | 1 | Power-down flag |
| cnt_load | output | 1 | Counter load flag |
| msel_sel | output | 1 | Modulus-select output flag |
| cmp_sel | output | 1 | Comparison-frequency output flag |
| lock_det_off | output | 1 | Lock-detect disable flag |

## Verification
A pin change takes two synchronizer clocks to reach the logic. The edge detectors add one more clock, so a committed frame or a captured shadow appears at the outputs three clocks after the strobe edge. Changes on `enh_n` and `direct` and on the parallel pins pass only through the synchronizer and are due two clocks after they occur. The bench holds every serial level for at least four clocks. Each expected value is scheduled for comparison ten clocks after the last stimulus it depends on, and no input changes until that comparison is done. Each comparison therefore lands well after its result is due and before the next stimulus can disturb it.

// File: rtl/scc_pkg.sv
package scc_pkg;
    localparam int FRAME_W = 21;
    localparam int DATA_W  = FRAME_W - 1;
    localparam int R_W     = 6;
    localparam int M_W     = 9;
    localparam int A_W     = 4;
    localparam int K_W     = 18;
    localparam int FLAG_W  = 6;
    localparam int PAR_W   = R_W + M_W + 1 + A_W + K_W;

    typedef struct packed {
        logic [R_W-1:0] r;
        logic [M_W-1:0] m;
        logic           pre;
        logic [A_W-1:0] a;
    } cnt_fields_t;

    typedef struct packed {
        logic [FRAME_W-1:0] msh;
        logic [FLAG_W-1:0]  esh;
        cnt_fields_t        prim;
        logic [K_W-1:0]     k;
        logic [FLAG_W-1:0]  shadow;
    } core_state_t;

    // Bit 19 is the first data bit in.
    function automatic cnt_fields_t unpack_prim(input logic [DATA_W-1:0] w);
        cnt_fields_t f;
        f.r   = {w[19:18], w[7:4]};
        f.m   = {w[17:16], w[14:8]};
        f.pre = w[15];
        f.a   = w[3:0];
        return f;
    endfunction
endpackage

// File: rtl/scc_sync.sv
module scc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_q [STAGES];
    logic [W-1:0] st_d [STAGES];

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= st_d[i];
            end
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/scc_edge.sv
module scc_edge #(
    parameter int           W         = 1,
    parameter logic [W-1:0] RISE_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (RISE_MASK[i]) begin : g_rise
            assign hit[i] = lvl[i] & ~prev_q[i];
        end else begin : g_fall
            assign hit[i] = ~lvl[i] & prev_q[i];
        end
    end
endmodule

// File: rtl/scc_frame_core.sv
module scc_frame_core
    import scc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata_s,
    input  logic              ewr_s,
    input  logic              swr_s,
    input  logic              enh_n_s,
    input  logic              direct_s,
    input  logic              sclk_rise,
    input  logic              swr_rise,
    input  logic              ewr_fall,
    input  cnt_fields_t       par_f,
    input  logic [K_W-1:0]    par_k,
    output cnt_fields_t       out_f,
    output logic [K_W-1:0]    out_k,
    output logic [FLAG_W-1:0] flags
);
    core_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (sclk_rise) begin
            if (!ewr_s) begin
                state_d.msh = {state_q.msh[FRAME_W-2:0], sdata_s};
            end else if (!swr_s) begin
                state_d.esh = {state_q.esh[FLAG_W-2:0], sdata_s};
            end
        end
        if (swr_rise && !ewr_s && !direct_s) begin
            if (state_q.msh[0]) begin
                state_d.k = state_q.msh[FRAME_W-1 -: K_W];
            end else begin
                state_d.prim = unpack_prim(state_q.msh[FRAME_W-1:1]);
            end
        end
        if (ewr_fall) begin
            state_d.shadow = state_q.esh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        out_f = direct_s ? par_f : state_q.prim;
        out_k = direct_s ? par_k : state_q.k;
        flags = state_q.shadow & {FLAG_W{~enh_n_s}};
    end
endmodule

// File: rtl/synth_serial_ctrl.sv
module synth_serial_ctrl
    import scc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sdata,
    input  logic           sclk,
    input  logic           swr,
    input  logic           ewr,
    input  logic           enh_n,
    input  logic           direct,
    input  logic [R_W-1:0] par_r,
    input  logic [M_W-1:0] par_m,
    input  logic           par_pre,
    input  logic [A_W-1:0] par_a,
    input  logic [K_W-1:0] par_k,
    output logic [R_W-1:0] out_r,
    output logic [M_W-1:0] out_m,
    output logic           out_pre,
    output logic [A_W-1:0] out_a,
    output logic [K_W-1:0] out_k,
    output logic           phase_sel,
    output logic           pwr_down,
    output logic           cnt_load,
    output logic           msel_sel,
    output logic           cmp_sel,
    output logic           lock_det_off
);
    localparam int CTL_W = 6;

    logic [CTL_W-1:0] ctl_s;
    logic [PAR_W-1:0] par_s;
    logic [2:0]       edges;
    cnt_fields_t      par_f, out_f;
    logic [K_W-1:0]   par_k_s;
    logic [FLAG_W-1:0] flags;

    scc_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sdata, sclk, swr, ewr, enh_n, direct}),
        .q(ctl_s)
    );

    scc_sync #(.W(PAR_W), .STAGES(SYNC_STAGES)) u_par_sync (
        .clk(clk), .rst_n(rst_n),
        .d({par_r, par_m, par_pre, par_a, par_k}),
        .q(par_s)
    );

    // bit 2: sclk rise, bit 1: swr rise, bit 0: ewr fall
    scc_edge #(.W(3), .RISE_MASK(3'b110)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .lvl(ctl_s[4:2]),
        .hit(edges)
    );

    assign par_f   = par_s[PAR_W-1:K_W];
    assign par_k_s = par_s[K_W-1:0];

    scc_frame_core u_core (
        .clk(clk), .rst_n(rst_n),
        .sdata_s(ctl_s[5]),
        .ewr_s(ctl_s[2]),
        .swr_s(ctl_s[3]),
        .enh_n_s(ctl_s[1]),
        .direct_s(ctl_s[0]),
        .sclk_rise(edges[2]),
        .swr_rise(edges[1]),
        .ewr_fall(edges[0]),
        .par_f(par_f),
        .par_k(par_k_s),
        .out_f(out_f),
        .out_k(out_k),
        .flags(flags)
    );

    assign out_r   = out_f.r;
    assign out_m   = out_f.m;
    assign out_pre = out_f.pre;
    assign out_a   = out_f.a;
    assign {phase_sel, pwr_down, cnt_load, msel_sel, cmp_sel, lock_det_off} = flags;
endmodule

// File: rtl/scc_checker.sv
module scc_checker
    import scc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ewr_s,
    input logic               swr_s,
    input logic               enh_n_s,
    input logic               direct_s,
    input logic               swr_rise,
    input logic               ewr_fall,
    input logic [FRAME_W-1:0] msh,
    input logic [FLAG_W-1:0]  esh,
    input cnt_fields_t        prim,
    input logic [K_W-1:0]     kw,
    input logic [FLAG_W-1:0]  shadow,
    input logic [FLAG_W-1:0]  flags
);
    // R5
    commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swr_rise |=> ($stable(prim) && $stable(kw)));

    // R10
    direct_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        direct_s |=> ($stable(prim) && $stable(kw)));

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ewr_fall |=> $stable(shadow));

    // R9
    flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enh_n_s |-> (flags == '0));

    // R11
    frame_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ewr_s |=> $stable(msh));

    // R7
    enh_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ewr_s || swr_s) |=> $stable(esh));
endmodule

bind scc_frame_core scc_checker u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .ewr_s(ewr_s),
    .swr_s(swr_s),
    .enh_n_s(enh_n_s),
    .direct_s(direct_s),
    .swr_rise(swr_rise),
    .ewr_fall(ewr_fall),
    .msh(state_q.msh),
    .esh(state_q.esh),
    .prim(state_q.prim),
    .kw(state_q.k),
    .shadow(state_q.shadow),
    .flags(flags)
);

// File: tb/synth_serial_ctrl_test.sv
`timescale 1ns/1ps
module synth_serial_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdata = 0, sclk = 0, swr = 0, ewr = 0, enh_n = 1, direct = 0;
    logic [5:0]  par_r = '0;
    logic [8:0]  par_m = '0;
    logic        par_pre = 0;
    logic [3:0]  par_a = '0;
    logic [17:0] par_k = '0;
    logic [5:0]  out_r;
    logic [8:0]  out_m;
    logic        out_pre;
    logic [3:0]  out_a;
    logic [17:0] out_k;
    logic phase_sel, pwr_down, cnt_load, msel_sel, cmp_sel, lock_det_off;

    synth_serial_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sdata(sdata), .sclk(sclk), .swr(swr),
        .ewr(ewr), .enh_n(enh_n), .direct(direct),
        .par_r(par_r), .par_m(par_m), .par_pre(par_pre), .par_a(par_a), .par_k(par_k),
        .out_r(out_r), .out_m(out_m), .out_pre(out_pre), .out_a(out_a), .out_k(out_k),
        .phase_sel(phase_sel), .pwr_down(pwr_down), .cnt_load(cnt_load),
        .msel_sel(msel_sel), .cmp_sel(cmp_sel), .lock_det_off(lock_det_off)
    );

    always #4 clk = ~clk;

    int cycle = 0;
    int total = 0;
    int bad = 0;
    bit done = 0;
    always @(posedge clk) cycle <= cycle + 1;

    // reference model, written from the requirements
    logic [20:0] m_frame = '0;
    logic [5:0]  m_enh = '0;
    logic [19:0] m_prim = '0;
    logic [17:0] m_k = '0;
    logic [5:0]  m_shadow = '0;

    int          due_q[$];
    logic [43:0] exp_q[$];
    string       tag_q[$];

    wire [43:0] obs = {out_r, out_m, out_pre, out_a, out_k,
                       phase_sel, pwr_down, cnt_load, msel_sel, cmp_sel, lock_det_off};

    function automatic logic [43:0] model_out();
        logic [5:0] r; logic [8:0] m; logic p; logic [3:0] a; logic [17:0] k; logic [5:0] f;
        if (direct) begin
            r = par_r; m = par_m; p = par_pre; a = par_a; k = par_k;
        end else begin
            // positions counted from first data bit in (bit 19 of m_prim)
            r = {m_prim[19], m_prim[18], m_prim[7], m_prim[6], m_prim[5], m_prim[4]};
            m = {m_prim[17], m_prim[16], m_prim[14], m_prim[13], m_prim[12],
                 m_prim[11], m_prim[10], m_prim[9], m_prim[8]};
            p = m_prim[15];
            a = m_prim[3:0];
            k = m_k;
        end
        f = enh_n ? 6'd0 : m_shadow;
        return {r, m, p, a, k, f};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input string tag);
        due_q.push_back(cycle + 10);
        exp_q.push_back(model_out());
        tag_q.push_back(tag);
        wait_clk(14);
    endtask

    task automatic send_bit(input logic b);
        sdata = b;
        wait_clk(4);
        sclk = 1'b1;
        if (!ewr) m_frame = {m_frame[19:0], b};
        else if (!swr) m_enh = {m_enh[4:0], b};
        wait_clk(4);
        sclk = 1'b0;
        wait_clk(4);
    endtask

    task automatic pulse_swr();
        swr = 1'b1;
        if (!ewr && !direct) begin
            if (m_frame[0]) m_k = m_frame[20:3];
            else m_prim = m_frame[20:1];
        end
        wait_clk(6);
        swr = 1'b0;
        wait_clk(6);
    endtask

    task automatic shift_frame(input logic [19:0] w, input logic adr);
        for (int i = 19; i >= 0; i--) send_bit(w[i]);
        send_bit(adr);
    endtask

    task automatic enh_start();
        ewr = 1'b1;
        wait_clk(6);
    endtask

    task automatic enh_end();
        ewr = 1'b0;
        m_shadow = m_enh;
        wait_clk(6);
    endtask

    task automatic enh_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    // monitor: pops and compares each item when it is due
    initial begin
        forever begin
            @(negedge clk);
            while (due_q.size() > 0 && due_q[0] <= cycle) begin
                total++;
                if (obs !== exp_q[0]) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", tag_q[0], obs, exp_q[0]);
                end
                void'(due_q.pop_front());
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            if (cycle > 150000 && !done) begin
                total++;
                bad++;
                $display("FAIL watchdog: actual=cycle %0d expected=finish", cycle);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        expect_now("R1 reset state");

        enh_n = 1'b0;
        shift_frame(20'hB6D29, 1'b0);
        pulse_swr();
        expect_now("R2 R3 primary frame");

        shift_frame(20'h5A5A7, 1'b1);
        pulse_swr();
        expect_now("R4 auxiliary frame, primary kept");

        shift_frame(20'h3C1E5, 1'b0);
        expect_now("R5 no strobe, no change");
        pulse_swr();
        expect_now("R5 commit on strobe");

        for (int i = 0; i < 4; i++) send_bit(i[0]);
        shift_frame(20'h9F0C3, 1'b0);
        pulse_swr();
        expect_now("R6 last 21 bits kept");

        enh_start();
        enh_bits(8'b00_101011);
        expect_now("R8 flags held during load");
        enh_end();
        expect_now("R8 shadow captured on falling strobe");

        enh_start();
        enh_bits(8'b11_010100);
        enh_end();
        expect_now("R8 second flag pattern");

        enh_n = 1'b1;
        expect_now("R9 flags masked by enable high");
        enh_n = 1'b0;
        expect_now("R9 flags restored by enable low");

        enh_start();
        swr = 1'b1;
        wait_clk(6);
        enh_bits(8'b00_111111);
        swr = 1'b0;
        wait_clk(6);
        enh_end();
        expect_now("R7 no enhancement shift while commit strobe high");

        enh_start();
        enh_bits(8'b00_000001);
        enh_end();
        expect_now("R7 enhancement shift with commit strobe low");

        shift_frame(20'h0F3A6, 1'b1);
        enh_start();
        enh_bits(8'b00_110011);
        enh_end();
        pulse_swr();
        expect_now("R11 frame kept across enhancement load");

        par_r = 6'h2B; par_m = 9'h15A; par_pre = 1'b1; par_a = 4'h9; par_k = 18'h2C3D5;
        direct = 1'b1;
        wait_clk(4);
        expect_now("R10 direct pins drive fields");
        shift_frame(20'hFFFFF, 1'b0);
        pulse_swr();
        expect_now("R10 serial commit ignored in direct mode");
        direct = 1'b0;
        expect_now("R10 stored words return after direct mode");

        wait_clk(20);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule